// File: doc/BRIEF.md
# Display Register Command Executor

This engine works through a queue of register-programming instructions held in a word-addressed memory and turns them into register writes on a display register bus. Software sets a control word (enable, and an option to hold off until a vertical blank), loads a head address, and then writes a tail address. Writing the tail is what starts a run. From then on the engine fetches 64-bit instructions one after another, decodes each one and acts on it. It reports busy until the fetch pointer reaches the tail.

Each instruction occupies two dwords. The lower dword is the payload and the upper dword carries the opcode, a byte-enable field and a register offset. Four kinds of instruction have an effect. A single write stores one value. An indexed write pushes a run of data dwords to one offset, and the run is zero-padded when its length is odd. A wait holds for a number of microsecond ticks or vertical-blank pulses. An interrupt instruction raises a one-cycle pulse. Any other opcode moves the pointer on and does nothing else. The engine never reads a register.

Top module: `disp_cmd_engine`

## Requirements
- R1: After reset `busy`, `reg_wr_valid`, `mem_rd_en` and `irq` are all 0, and while `busy` is 0 the engine makes no memory read and no register write.
- R2: A tail write while the stored enable bit is 1 raises `busy` in the next cycle. A tail write while enable is 0 starts nothing.
- R3: If the stored vblank-wait bit is 1 when a run starts, no instruction is fetched until a `vblank` pulse arrives.
- R4: Instructions start at even dword addresses. Dword 0 is the payload. Dword 1 holds the opcode in bits 31:24, the byte enable in bits 23:20 and the register offset in bits 19:0. Opcode 0x01 writes the payload to the offset using that byte enable.
- R5: Opcode 0x09 treats the payload as a count N. The N dwords that follow are written in order to the same offset with byte enable 0xF. When N is odd, one pad dword is skipped, and N = 0 writes nothing.
- R6: Opcode 0x02 holds execution until `payload` pulses of `us_tick` have been seen after the instruction was decoded.
- R7: Opcode 0x04 holds execution until `payload` pulses of `vblank` have been seen.
- R8: Opcode 0x07 drives `irq` high for exactly one cycle.
- R9: Opcodes 0x00, 0x03, 0x05, 0x06, 0x0A and any undefined value (0x0B is an example) advance by two dwords with no write and no interrupt. This covers the zero fill in front of the tail.
- R10: `busy` drops once the fetch pointer equals the tail. Bits 5:0 of the tail byte address are ignored, so the tail always sits on a 64-byte line.
- R11: While `reg_wr_valid` is high and `reg_wr_ready` is low, the write is held with address, data and byte enable stable.
- R12: Writing the control word with enable 0 returns the engine to idle at once, even in the middle of a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_enable | input | 1 | Enable bit of the control word |
| ctl_vb_wait | input | 1 | Vblank-wait bit of the control word |
| head_we | input | 1 | Head address write strobe |
| head_addr | input | MEM_AW+2 | Head byte address (8-byte aligned) |
| tail_we | input | 1 | Tail address write strobe, starts a run |
| tail_addr | input | MEM_AW+2 | Tail byte address |
| busy | output | 1 | Run in progress |
| vblank | input | 1 | One-cycle vertical blank pulse |
| us_tick | input | 1 | One-cycle microsecond tick |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | MEM_AW | Memory dword address |
| mem_rd_data | input | 32 | Read data, one cycle after the request |
| reg_wr_valid | output | 1 | Register write request |
| reg_wr_ready | input | 1 | Register bus accepts the write |
| reg_wr_addr | output | 20 | Register offset |
| reg_wr_data | output | 32 | Register write data |
| reg_wr_be | output | 4 | Byte enables |
| irq | output | 1 | Interrupt pulse |

## Verification
Some properties are checked on every cycle: the engine stays quiet on both buses while idle, it does not fetch while armed for a vblank, instruction fetches land on even dwords, a stalled write holds steady, the interrupt lasts one cycle, and reaching the tail drops busy. Other behaviour can only be shown by the bench scenarios, because it depends on memory contents and on counting: the decoded order and values of writes, the pad skip after an odd indexed run, no-op opcodes leaving no trace, exact tick and vblank counts for waits, and aborting a run or ignoring a start when enable is off.

// File: rtl/disp_cmd_pkg.sv
package disp_cmd_pkg;
   localparam int DW    = 32;
   localparam int OFF_W = 20;
   localparam int BE_W  = 4;

   localparam logic [7:0] OPC_WRITE   = 8'h01;
   localparam logic [7:0] OPC_WAIT_US = 8'h02;
   localparam logic [7:0] OPC_WAIT_VB = 8'h04;
   localparam logic [7:0] OPC_IRQ     = 8'h07;
   localparam logic [7:0] OPC_INDEXED = 8'h09;

   typedef enum logic [2:0] {
      K_SKIP, K_WRITE, K_INDEXED, K_WAIT_US, K_WAIT_VB, K_IRQ
   } cmd_kind_t;

   typedef enum logic [3:0] {
      S_IDLE, S_ARM, S_FETCH, S_RD1, S_CAPT, S_EXEC, S_WR,
      S_WAIT, S_IX_RD, S_IX_CAP, S_IX_WR
   } eng_state_t;
endpackage

// File: rtl/dce_decode.sv
module dce_decode
   import disp_cmd_pkg::*;
(
   input  logic [DW-1:0]    cmd_word,
   output cmd_kind_t        kind,
   output logic [BE_W-1:0]  be,
   output logic [OFF_W-1:0] offset
);
   assign be     = cmd_word[23:20];
   assign offset = cmd_word[OFF_W-1:0];

   always_comb begin
      unique case (cmd_word[31:24])
         OPC_WRITE:   kind = K_WRITE;
         OPC_INDEXED: kind = K_INDEXED;
         OPC_WAIT_US: kind = K_WAIT_US;
         OPC_WAIT_VB: kind = K_WAIT_VB;
         OPC_IRQ:     kind = K_IRQ;
         default:     kind = K_SKIP;
      endcase
   end
endmodule

// File: rtl/dce_wait.sv
module dce_wait #(
   parameter int CW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   input  logic          dec,
   output logic          zero
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cnt_q <= '0;
      else if (load)                 cnt_q <= load_val;
      else if (dec && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);
endmodule

// File: rtl/disp_cmd_engine.sv
module disp_cmd_engine
   import disp_cmd_pkg::*;
#(
   parameter int MEM_AW         = 16,
   parameter int WAIT_W         = 32,
   parameter bit IDX_USE_CMD_BE = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ctl_we,
   input  logic               ctl_enable,
   input  logic               ctl_vb_wait,
   input  logic               head_we,
   input  logic [MEM_AW+1:0]  head_addr,
   input  logic               tail_we,
   input  logic [MEM_AW+1:0]  tail_addr,
   output logic               busy,
   input  logic               vblank,
   input  logic               us_tick,
   output logic               mem_rd_en,
   output logic [MEM_AW-1:0]  mem_rd_addr,
   input  logic [31:0]        mem_rd_data,
   output logic               reg_wr_valid,
   input  logic               reg_wr_ready,
   output logic [19:0]        reg_wr_addr,
   output logic [31:0]        reg_wr_data,
   output logic [3:0]         reg_wr_be,
   output logic               irq
);
   localparam int LINE_WORDS_LOG2 = 4;

   if (MEM_AW < LINE_WORDS_LOG2 + 2) begin : g_bad_aw
      $error("MEM_AW too small to hold one 64-byte line");
   end
   if (WAIT_W < 1 || WAIT_W > DW) begin : g_bad_ww
      $error("WAIT_W must lie in 1..32");
   end

   eng_state_t        state_q;
   logic              en_q, vbw_q, wvb_q, irq_q;
   logic [MEM_AW-1:0] head_q, tail_q, ptr_q;
   logic [DW-1:0]     pay_q, cmd_q, wdat_q, cnt_q;

   cmd_kind_t        kind;
   logic [BE_W-1:0]  cmd_be;
   logic [OFF_W-1:0] cmd_off;
   logic             wt_zero, wt_load, wt_dec, abort;
   logic [BE_W-1:0]  idx_be;

   dce_decode u_dec (
      .cmd_word (cmd_q),
      .kind     (kind),
      .be       (cmd_be),
      .offset   (cmd_off)
   );

   assign wt_load = (state_q == S_EXEC) && (kind == K_WAIT_US || kind == K_WAIT_VB);
   assign wt_dec  = (state_q == S_WAIT) && (wvb_q ? vblank : us_tick);

   dce_wait #(.CW(WAIT_W)) u_wait (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (wt_load),
      .load_val (pay_q[WAIT_W-1:0]),
      .dec      (wt_dec),
      .zero     (wt_zero)
   );

   if (IDX_USE_CMD_BE) begin : g_idx_be_cmd
      assign idx_be = cmd_be;
   end else begin : g_idx_be_full
      assign idx_be = '1;
   end

   assign abort = ctl_we && !ctl_enable;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         en_q    <= 1'b0;
         vbw_q   <= 1'b0;
         wvb_q   <= 1'b0;
         irq_q   <= 1'b0;
         head_q  <= '0;
         tail_q  <= '0;
         ptr_q   <= '0;
         pay_q   <= '0;
         cmd_q   <= '0;
         wdat_q  <= '0;
         cnt_q   <= '0;
      end else begin
         irq_q <= 1'b0;
         if (ctl_we) begin
            en_q  <= ctl_enable;
            vbw_q <= ctl_vb_wait;
         end
         if (head_we) head_q <= {head_addr[MEM_AW+1:3], 1'b0};
         if (tail_we) tail_q <= {tail_addr[MEM_AW+1:6], {LINE_WORDS_LOG2{1'b0}}};
         if (abort) begin
            state_q <= S_IDLE;
         end else begin
            unique case (state_q)
               S_IDLE: if (tail_we && en_q) begin
                  ptr_q   <= head_q;
                  state_q <= vbw_q ? S_ARM : S_FETCH;
               end
               S_ARM:   if (vblank) state_q <= S_FETCH;
               S_FETCH: state_q <= (ptr_q == tail_q) ? S_IDLE : S_RD1;
               S_RD1: begin
                  pay_q   <= mem_rd_data;
                  state_q <= S_CAPT;
               end
               S_CAPT: begin
                  cmd_q   <= mem_rd_data;
                  ptr_q   <= ptr_q + 2'd2;
                  state_q <= S_EXEC;
               end
               S_EXEC: begin
                  unique case (kind)
                     K_WRITE:   state_q <= S_WR;
                     K_INDEXED: begin
                        cnt_q   <= pay_q;
                        state_q <= (pay_q == '0) ? S_FETCH : S_IX_RD;
                     end
                     K_WAIT_US: begin wvb_q <= 1'b0; state_q <= S_WAIT; end
                     K_WAIT_VB: begin wvb_q <= 1'b1; state_q <= S_WAIT; end
                     K_IRQ:     begin irq_q <= 1'b1; state_q <= S_FETCH; end
                     default:   state_q <= S_FETCH;
                  endcase
               end
               S_WR:   if (reg_wr_ready) state_q <= S_FETCH;
               S_WAIT: if (wt_zero) state_q <= S_FETCH;
               S_IX_RD: begin
                  ptr_q   <= ptr_q + 1'b1;
                  state_q <= S_IX_CAP;
               end
               S_IX_CAP: begin
                  wdat_q  <= mem_rd_data;
                  state_q <= S_IX_WR;
               end
               S_IX_WR: if (reg_wr_ready) begin
                  cnt_q <= cnt_q - 1'b1;
                  if (cnt_q == 32'd1) begin
                     ptr_q   <= ptr_q + {{(MEM_AW-1){1'b0}}, ptr_q[0]};
                     state_q <= S_FETCH;
                  end else begin
                     state_q <= S_IX_RD;
                  end
               end
               default: state_q <= S_IDLE;
            endcase
         end
      end
   end

   assign busy         = (state_q != S_IDLE);
   assign mem_rd_en    = ((state_q == S_FETCH) && (ptr_q != tail_q)) ||
                         (state_q == S_RD1) || (state_q == S_IX_RD);
   assign mem_rd_addr  = (state_q == S_RD1) ? ptr_q + 1'b1 : ptr_q;
   assign reg_wr_valid = (state_q == S_WR) || (state_q == S_IX_WR);
   assign reg_wr_addr  = cmd_off;
   assign reg_wr_data  = (state_q == S_WR) ? pay_q : wdat_q;
   assign reg_wr_be    = (state_q == S_WR) ? cmd_be : idx_be;
   assign irq          = irq_q;

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!reg_wr_valid && !mem_rd_en)); // R1
   AST_ARM_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_ARM) |-> !mem_rd_en); // R3
   AST_INS_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_FETCH && mem_rd_en) |-> !mem_rd_addr[0]); // R4
   AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq); // R8
   AST_DONE_AT_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_FETCH && ptr_q == tail_q) |=> !busy); // R10
   AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_valid && !reg_wr_ready && !abort) |=>
      (reg_wr_valid && $stable(reg_wr_addr) && $stable(reg_wr_data) && $stable(reg_wr_be))); // R11
   AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> !busy); // R12
endmodule

// File: tb/disp_cmd_engine_tb_top.sv
module disp_cmd_engine_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int MAW = 16;

   logic clk = 1'b0, rst_n = 1'b0;
   logic ctl_we = 0, ctl_enable = 0, ctl_vb_wait = 0, head_we = 0, tail_we = 0;
   logic [MAW+1:0] head_addr = '0, tail_addr = '0;
   logic busy, mem_rd_en, reg_wr_valid, irq;
   logic [MAW-1:0] mem_rd_addr;
   logic [31:0] mem_rd_data = '0, reg_wr_data;
   logic [19:0] reg_wr_addr;
   logic [3:0] reg_wr_be;
   logic reg_wr_ready = 1'b1;
   logic us_man = 0, us_auto = 0, vb_man = 0, vb_auto = 0, auto_on = 0;
   logic us_tick, vblank;
   int   rdy_mode = 0;

   assign us_tick = us_man | us_auto;
   assign vblank  = vb_man | vb_auto;

   disp_cmd_engine #(.MEM_AW(MAW)) dut_i (
      .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_enable(ctl_enable),
      .ctl_vb_wait(ctl_vb_wait), .head_we(head_we), .head_addr(head_addr),
      .tail_we(tail_we), .tail_addr(tail_addr), .busy(busy), .vblank(vblank),
      .us_tick(us_tick), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
      .mem_rd_data(mem_rd_data), .reg_wr_valid(reg_wr_valid),
      .reg_wr_ready(reg_wr_ready), .reg_wr_addr(reg_wr_addr),
      .reg_wr_data(reg_wr_data), .reg_wr_be(reg_wr_be), .irq(irq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   logic [31:0] mem [0:1023];
   logic [19:0] exp_a [0:255];
   logic [31:0] exp_d [0:255];
   logic [3:0]  exp_b [0:255];
   logic [19:0] got_a [0:255];
   logic [31:0] got_d [0:255];
   logic [3:0]  got_b [0:255];
   int ne = 0, ng = 0, nirq = 0, nrd = 0, exp_irq = 0, wp = 0;
   int checks = 0, errors = 0;
   bit done = 0;

   always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr[9:0]];

   always @(posedge clk) if (rst_n) begin
      if (reg_wr_valid && reg_wr_ready && ng < 256) begin
         got_a[ng] = reg_wr_addr; got_d[ng] = reg_wr_data; got_b[ng] = reg_wr_be;
         ng = ng + 1;
      end
      if (irq) nirq = nirq + 1;
      if (mem_rd_en) nrd = nrd + 1;
   end

   always @(negedge clk) begin
      reg_wr_ready <= (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? (($urandom % 3) != 0) : 1'b0;
      us_auto <= auto_on && (($urandom % 4) == 0);
      vb_auto <= auto_on && (($urandom % 8) == 0);
   end

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic int line_round(input int w);
      return (w + 15) / 16 * 16;
   endfunction

   task automatic start_stream(input int base);
      wp = base; ne = 0; ng = 0; nirq = 0; nrd = 0; exp_irq = 0;
   endtask

   task automatic emit(input logic [31:0] a, input logic [31:0] b);
      mem[wp] = a; mem[wp+1] = b; wp += 2;
   endtask

   task automatic expect_wr(input logic [19:0] a, input logic [3:0] b, input logic [31:0] d);
      exp_a[ne] = a; exp_b[ne] = b; exp_d[ne] = d; ne++;
   endtask

   task automatic put_wr(input logic [19:0] off, input logic [3:0] be, input logic [31:0] v);
      emit(v, {8'h01, be, off});
      expect_wr(off, be, v);
   endtask

   task automatic put_idx(input logic [19:0] off, input int n);
      emit(n, {8'h09, 4'h0, off});
      for (int i = 0; i < n; i++) begin
         logic [31:0] d;
         d = $urandom;
         mem[wp] = d; wp++;
         expect_wr(off, 4'hF, d);
      end
      if (n % 2 == 1) begin mem[wp] = 32'h0; wp++; end
   endtask

   task automatic put_op(input logic [7:0] op, input logic [31:0] pay);
      emit(pay, {op, 4'h0, 20'h0});
      if (op == 8'h07) exp_irq++;
   endtask

   task automatic close_stream(output int tail);
      tail = line_round(wp);
      while (wp < tail) begin mem[wp] = 32'h0; wp++; end
   endtask

   task automatic set_ctl(input bit en, input bit vb);
      @(negedge clk); ctl_we = 1; ctl_enable = en; ctl_vb_wait = vb;
      @(negedge clk); ctl_we = 0;
   endtask

   task automatic go(input int head, input int tail, input bit vb, input int low);
      set_ctl(1'b1, vb);
      head_we = 1; head_addr = (MAW+2)'(head * 4);
      @(negedge clk); head_we = 0;
      tail_we = 1; tail_addr = (MAW+2)'(tail * 4 + low);
      @(negedge clk); tail_we = 0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
   endtask

   task automatic compare_log(input string req);
      check(ng == ne, req, "write count", ng, ne);
      for (int i = 0; i < ne && i < ng; i++) begin
         check(got_a[i] == exp_a[i], req, "write addr", got_a[i], exp_a[i]);
         check(got_d[i] == exp_d[i], req, "write data", got_d[i], exp_d[i]);
         check(got_b[i] == exp_b[i], req, "write be", got_b[i], exp_b[i]);
      end
   endtask

   task automatic tick_us(); @(negedge clk); us_man = 1; @(negedge clk); us_man = 0; endtask
   task automatic tick_vb(); @(negedge clk); vb_man = 1; @(negedge clk); vb_man = 0; endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog run did not finish actual=0 expected=1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int tail, seed_v;
      seed_v = $urandom(32'd2024);
      for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      check(!busy && !reg_wr_valid && !mem_rd_en && !irq, "R1", "reset outputs",
            {busy, reg_wr_valid, mem_rd_en, irq}, 0);

      // Directed mix: R4 R5 R8 R9 R10
      start_stream(0);
      put_wr(20'h12345, 4'h3, 32'hCAFE_0001);
      put_wr(20'h00A10, 4'hF, 32'h1111_2222);
      put_op(8'h0B, 32'hFFFF_FFFF);
      put_op(8'h00, 32'h5);
      put_op(8'h0A, 32'h7);
      put_op(8'h03, 32'h9);
      put_op(8'h05, 32'h1);
      put_op(8'h06, 32'h1);
      put_idx(20'h0BEEF, 3);
      put_idx(20'h00044, 2);
      put_idx(20'h00050, 0);
      put_op(8'h07, 32'h0);
      put_wr(20'h00077, 4'h1, 32'h0000_00AB);
      close_stream(tail);
      go(0, tail, 1'b0, 5);
      check(busy, "R2", "busy after tail write", busy, 1);
      wait_idle();
      check(!busy, "R10", "busy drops at tail", busy, 0);
      compare_log("R4_R5_R9");
      check(nirq == 1, "R8", "irq pulses", nirq, 1);

      // R2: tail write with enable cleared starts nothing
      set_ctl(1'b0, 1'b0);
      start_stream(0);
      @(negedge clk); tail_we = 1; tail_addr = (MAW+2)'(tail * 4);
      @(negedge clk); tail_we = 0;
      repeat (3) @(negedge clk);
      check(!busy && nrd == 0, "R2", "no start without enable", {busy, 32'(nrd)}, 0);

      // R3: vblank gate
      start_stream(256);
      put_wr(20'h00300, 4'hF, 32'hDEAD_BEEF);
      close_stream(tail);
      go(256, tail, 1'b1, 0);
      repeat (20) @(negedge clk);
      check(busy && nrd == 0, "R3", "no fetch before vblank", nrd, 0);
      tick_vb();
      wait_idle();
      compare_log("R3");

      // R6: microsecond wait
      start_stream(0);
      put_op(8'h02, 32'd4);
      put_wr(20'h00400, 4'hF, 32'h0000_0004);
      close_stream(tail);
      go(0, tail, 1'b0, 0);
      repeat (30) @(negedge clk);
      check(busy && ng == 0, "R6", "held with no ticks", ng, 0);
      repeat (3) tick_us();
      repeat (5) @(negedge clk);
      check(ng == 0, "R6", "held after 3 of 4 ticks", ng, 0);
      tick_us();
      wait_idle();
      compare_log("R6");

      // R7: vblank-count wait
      start_stream(0);
      put_op(8'h04, 32'd2);
      put_wr(20'h00500, 4'hF, 32'h0000_0005);
      close_stream(tail);
      go(0, tail, 1'b0, 0);
      repeat (10) @(negedge clk);
      tick_vb();
      repeat (5) @(negedge clk);
      check(busy && ng == 0, "R7", "held after 1 of 2 vblanks", ng, 0);
      tick_vb();
      wait_idle();
      compare_log("R7");

      // R11: stall while ready low
      rdy_mode = 2;
      start_stream(0);
      put_wr(20'h00ABC, 4'h6, 32'h7777_8888);
      close_stream(tail);
      go(0, tail, 1'b0, 0);
      repeat (12) @(negedge clk);
      check(reg_wr_valid && reg_wr_addr == 20'h00ABC && reg_wr_data == 32'h7777_8888 &&
            reg_wr_be == 4'h6 && ng == 0, "R11", "held write",
            {reg_wr_data, 12'h0, reg_wr_addr}, {32'h7777_8888, 12'h0, 20'h00ABC});
      rdy_mode = 0;
      wait_idle();
      compare_log("R11");

      // R12: abort in the middle of a wait
      start_stream(0);
      put_op(8'h02, 32'd1000);
      put_wr(20'h00600, 4'hF, 32'h6);
      close_stream(tail);
      go(0, tail, 1'b0, 0);
      repeat (10) @(negedge clk);
      set_ctl(1'b0, 1'b0);
      check(!busy, "R12", "idle after abort", busy, 0);
      repeat (20) @(negedge clk);
      check(ng == 0, "R12", "no write after abort", ng, 0);

      // Random streams, random ready, auto ticks: R4 R5 R6 R8 R9
      rdy_mode = 1; auto_on = 1;
      for (int r = 0; r < 8; r++) begin
         int base;
         base = (r % 2) * 256;
         start_stream(base);
         for (int k = 0; k < 8; k++) begin
            case ($urandom % 5)
               0: put_wr(20'($urandom), 4'($urandom), $urandom);
               1: put_idx(20'($urandom), $urandom % 6);
               2: begin
                  logic [7:0] ops [6];
                  ops = '{8'h00, 8'h03, 8'h05, 8'h06, 8'h0A, 8'h0B};
                  put_op(ops[$urandom % 6], $urandom);
               end
               3: put_op(8'h07, $urandom);
               default: put_op(8'h02, 1 + $urandom % 3);
            endcase
         end
         close_stream(tail);
         go(base, tail, 1'b0, $urandom % 64);
         wait_idle();
         check(!busy, "R10", "random run finished", busy, 0);
         compare_log("R5_random");
         check(nirq == exp_irq, "R8", "random irq count", nirq, exp_irq);
      end
      auto_on = 0; rdy_mode = 0;

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule